// File: doc/BRIEF.md
# Two-Dimensional Nested Page Walker

This block turns a guest virtual address into a system physical address for a processor that runs virtual machines. Two page table hierarchies are involved. The guest table, owned by the guest kernel, maps guest virtual pages to guest physical pages. The nested table, owned by the hypervisor, maps guest physical pages to system physical pages. Each pointer in the guest hierarchy is a guest physical address. That includes the guest root, so every guest table pointer must go through a complete nested walk before the guest entry it points to can be fetched.

A request carries three values: the guest virtual address, the guest root (a guest physical address) and the nested root (a system physical address). The walker then runs a fixed sequence of dependent reads through a memory port that allows one outstanding read. It returns either the system physical address or a fault, together with a flag that says which table the fault came from. The walk must stop when it meets an entry that is not present. A debug output counts the reads of the current walk.

Top module: `nested_walk_engine`

## Requirements
- R1: `req_ready` is high only while the walker is idle, and no walk is in progress at that time. A request presented while a walk is busy is not taken, and the result returned is the one for the request already accepted.
- R2: Every read address is the 4 KB-aligned table frame shifted left by 12, plus a 9-bit index times 8, so bits 2:0 are always zero. The guest indices come from virtual address bits 47:39, 38:30, 29:21 and 20:12, in that order. The nested indices come from the same bit positions of the guest physical address being translated.
- R3: The reads run in a fixed order. First comes a four-read nested walk of the guest root. Then, for each of the four guest levels in turn, there is one guest entry read followed by a four-read nested walk of the frame that entry returns. The first read hits the nested root table, and the fifth read hits the guest top-level entry.
- R4: On success, `rsp_spa` equals the frame from the last nested entry concatenated with virtual address bits 11:0.
- R5: A successful walk issues exactly 24 reads. `dbg_read_count` rises by one on each read handshake and is cleared when a request is accepted.
- R6: If a guest entry has bit 0 clear, the walk stops at once. The response then has `rsp_fault`=1, `rsp_fault_nested`=0 and `rsp_spa`=0, and no further read is issued.
- R7: If a nested entry has bit 0 clear, the walk stops with `rsp_fault`=1, `rsp_fault_nested`=1 and `rsp_spa`=0.
- R8: The response outputs stay stable while `rsp_valid` is high and `rsp_ready` is low.
- R9: `mem_req_valid` and `mem_req_addr` stay stable until `mem_req_ready` is seen. Any delay before the request is accepted, and any delay before the response arrives, is tolerated.
- R10: In an entry, bit 0 is the present flag and bits 51:12 are the next frame. Bits 63:52 and 11:1 do not affect the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request taken |
| req_gva | input | 48 | Guest virtual address |
| req_groot | input | 52 | Guest root table pointer (guest physical) |
| req_nroot | input | 52 | Nested root table pointer (system physical) |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | 52 | Entry address to read |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | 64 | 8-byte table entry |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Result consumed |
| rsp_spa | output | 52 | System physical address, zero on fault |
| rsp_fault | output | 1 | Walk ended on a non-present entry |
| rsp_fault_nested | output | 1 | Fault came from the nested table |
| dbg_read_count | output | 8 | Reads issued in the current walk |

## Verification
Every read address is built from the walker's level counters and its latched frame. A wrong level counter or phase flag therefore shows up at the memory port within one read, as an entry address that does not match the one the bench computes from the tables it built. A wrong counter also changes the read total, which is visible when the response arrives. A stale frame sends the next read into a table the bench never wrote, so the walk ends in a fault the bench did not predict. An error in the final stage shows directly in `rsp_spa` or in the fault flags.

// File: rtl/nwe_pkg.sv
package nwe_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2,
      ST_DONE  = 2'd3
   } nwe_state_e;

   localparam int PRESENT_BIT = 0;
endpackage

// File: rtl/nwe_index_sel.sv
// Picks one index field out of a packed source; level 0 is the topmost field.
module nwe_index_sel #(
   parameter int LEVELS = 4,
   parameter int IDX_W  = 9,
   parameter int BASE   = 12,
   parameter int SRC_W  = 48,
   parameter int SEL_W  = 3
) (
   input  logic [SRC_W-1:0] src,
   input  logic [SEL_W-1:0] level,
   output logic [IDX_W-1:0] idx
);
   logic [IDX_W-1:0] field [LEVELS];

   generate
      for (genvar j = 0; j < LEVELS; j++) begin : g_field
         assign field[j] = src[BASE + IDX_W*(LEVELS-1-j) +: IDX_W];
      end
   endgenerate

   always_comb begin
      idx = '0;
      for (int j = 0; j < LEVELS; j++) begin
         if (level == SEL_W'(j)) idx = field[j];
      end
   end
endmodule

// File: rtl/nwe_addr_gen.sv
// Entry address = table frame * page size + index * entry size.
module nwe_addr_gen #(
   parameter int PA_W        = 52,
   parameter int OFF_W       = 12,
   parameter int IDX_W       = 9,
   parameter int ENTRY_BYTES = 8
) (
   input  logic [PA_W-OFF_W-1:0] base_frame,
   input  logic [IDX_W-1:0]      idx,
   output logic [PA_W-1:0]       addr
);
   localparam int SHIFT = $clog2(ENTRY_BYTES);

   logic [PA_W-1:0] offset;

   assign offset = PA_W'(idx) << SHIFT;
   assign addr   = {base_frame, {OFF_W{1'b0}}} + offset;
endmodule

// File: rtl/nwe_entry_decode.sv
module nwe_entry_decode #(
   parameter int ENTRY_W = 64,
   parameter int PA_W    = 52,
   parameter int OFF_W   = 12
) (
   input  logic [ENTRY_W-1:0]    data,
   output logic                  present,
   output logic [PA_W-OFF_W-1:0] frame
);
   import nwe_pkg::*;

   assign present = data[PRESENT_BIT];
   assign frame   = data[PA_W-1:OFF_W];
endmodule

// File: rtl/nwe_walk_fsm.sv
module nwe_walk_fsm #(
   parameter int VA_W    = 48,
   parameter int PA_W    = 52,
   parameter int OFF_W   = 12,
   parameter int G_LVL   = 4,
   parameter int N_LVL   = 4,
   parameter int GSEL_W  = 3,
   parameter int NSEL_W  = 2,
   parameter int CNT_W   = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic [VA_W-1:0]       req_gva,
   input  logic [PA_W-OFF_W-1:0] req_groot_frame,
   input  logic [PA_W-OFF_W-1:0] req_nroot_frame,
   output logic                  req_ready,
   output logic                  mem_req_valid,
   input  logic                  mem_req_ready,
   input  logic                  mem_rsp_valid,
   input  logic                  ent_present,
   input  logic [PA_W-OFF_W-1:0] ent_frame,
   output logic                  rsp_valid,
   input  logic                  rsp_ready,
   output logic [PA_W-1:0]       rsp_spa,
   output logic                  rsp_fault,
   output logic                  rsp_fault_nested,
   output logic [CNT_W-1:0]      read_count,
   output logic [VA_W-1:0]       gva_q,
   output logic [PA_W-OFF_W-1:0] gpa_frame_q,
   output logic [GSEL_W-1:0]     g_lvl,
   output logic [NSEL_W-1:0]     n_lvl,
   output logic                  in_guest,
   output logic [PA_W-OFF_W-1:0] walk_base
);
   import nwe_pkg::*;

   localparam int FRAME_W = PA_W - OFF_W;

   nwe_state_e           state;
   logic [FRAME_W-1:0]   nroot_q;
   logic                 last_nested;
   logic                 last_guest;

   assign req_ready     = (state == ST_IDLE);
   assign mem_req_valid = (state == ST_ISSUE);
   assign rsp_valid     = (state == ST_DONE);
   assign last_nested   = (n_lvl == NSEL_W'(N_LVL-1));
   assign last_guest    = (g_lvl == GSEL_W'(G_LVL));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state            <= ST_IDLE;
         gva_q            <= '0;
         gpa_frame_q      <= '0;
         nroot_q          <= '0;
         walk_base        <= '0;
         g_lvl            <= '0;
         n_lvl            <= '0;
         in_guest         <= 1'b0;
         read_count       <= '0;
         rsp_spa          <= '0;
         rsp_fault        <= 1'b0;
         rsp_fault_nested <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  gva_q            <= req_gva;
                  gpa_frame_q      <= req_groot_frame;
                  nroot_q          <= req_nroot_frame;
                  walk_base        <= req_nroot_frame;
                  g_lvl            <= '0;
                  n_lvl            <= '0;
                  in_guest         <= 1'b0;
                  read_count       <= '0;
                  rsp_spa          <= '0;
                  rsp_fault        <= 1'b0;
                  rsp_fault_nested <= 1'b0;
                  state            <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               if (mem_req_ready) begin
                  read_count <= read_count + CNT_W'(1);
                  state      <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (mem_rsp_valid) begin
                  if (!ent_present) begin
                     rsp_fault        <= 1'b1;
                     rsp_fault_nested <= !in_guest;
                     rsp_spa          <= '0;
                     state            <= ST_DONE;
                  end else if (in_guest) begin
                     gpa_frame_q <= ent_frame;
                     g_lvl       <= g_lvl + GSEL_W'(1);
                     n_lvl       <= '0;
                     in_guest    <= 1'b0;
                     walk_base   <= nroot_q;
                     state       <= ST_ISSUE;
                  end else if (last_nested) begin
                     if (last_guest) begin
                        rsp_spa <= {ent_frame, gva_q[OFF_W-1:0]};
                        state   <= ST_DONE;
                     end else begin
                        in_guest  <= 1'b1;
                        walk_base <= ent_frame;
                        state     <= ST_ISSUE;
                     end
                  end else begin
                     n_lvl     <= n_lvl + NSEL_W'(1);
                     walk_base <= ent_frame;
                     state     <= ST_ISSUE;
                  end
               end
            end
            ST_DONE: begin
               if (rsp_ready) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/nested_walk_engine.sv
module nested_walk_engine #(
   parameter int VA_W        = 48,
   parameter int PA_W        = 52,
   parameter int OFF_W       = 12,
   parameter int IDX_W       = 9,
   parameter int G_LVL       = 4,
   parameter int N_LVL       = 4,
   parameter int ENTRY_W     = 64,
   parameter int ENTRY_BYTES = 8,
   parameter int CNT_W       = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [VA_W-1:0]    req_gva,
   input  logic [PA_W-1:0]    req_groot,
   input  logic [PA_W-1:0]    req_nroot,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic [PA_W-1:0]    mem_req_addr,
   input  logic               mem_rsp_valid,
   input  logic [ENTRY_W-1:0] mem_rsp_data,
   output logic               rsp_valid,
   input  logic               rsp_ready,
   output logic [PA_W-1:0]    rsp_spa,
   output logic               rsp_fault,
   output logic               rsp_fault_nested,
   output logic [CNT_W-1:0]   dbg_read_count
);
   localparam int FRAME_W    = PA_W - OFF_W;
   localparam int GSEL_W     = $clog2(G_LVL + 1);
   localparam int NSEL_W     = (N_LVL > 1) ? $clog2(N_LVL) : 1;
   localparam int TOTAL_RD   = G_LVL*N_LVL + G_LVL + N_LVL;

   generate
      if (IDX_W*G_LVL + OFF_W != VA_W) begin : g_bad_va
         $error("virtual address width does not match levels and index width");
      end
      if (IDX_W*N_LVL > FRAME_W) begin : g_bad_pa
         $error("nested index fields exceed the physical frame width");
      end
      if ((1 << CNT_W) <= TOTAL_RD) begin : g_bad_cnt
         $error("read counter too narrow for a full walk");
      end
      if (ENTRY_W < PA_W || (1 << $clog2(ENTRY_BYTES)) != ENTRY_BYTES) begin : g_bad_ent
         $error("entry format does not hold a physical frame");
      end
   endgenerate

   logic [VA_W-1:0]    gva_q;
   logic [FRAME_W-1:0] gpa_frame_q;
   logic [GSEL_W-1:0]  g_lvl;
   logic [NSEL_W-1:0]  n_lvl;
   logic               in_guest;
   logic [FRAME_W-1:0] walk_base;
   logic [IDX_W-1:0]   g_idx;
   logic [IDX_W-1:0]   n_idx;
   logic [IDX_W-1:0]   sel_idx;
   logic               ent_present;
   logic [FRAME_W-1:0] ent_frame;

   nwe_index_sel #(
      .LEVELS(G_LVL), .IDX_W(IDX_W), .BASE(OFF_W), .SRC_W(VA_W), .SEL_W(GSEL_W)
   ) u_gsel (
      .src(gva_q), .level(g_lvl), .idx(g_idx)
   );

   nwe_index_sel #(
      .LEVELS(N_LVL), .IDX_W(IDX_W), .BASE(0), .SRC_W(FRAME_W), .SEL_W(NSEL_W)
   ) u_nsel (
      .src(gpa_frame_q), .level(n_lvl), .idx(n_idx)
   );

   assign sel_idx = in_guest ? g_idx : n_idx;

   nwe_addr_gen #(
      .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENTRY_BYTES(ENTRY_BYTES)
   ) u_addr (
      .base_frame(walk_base), .idx(sel_idx), .addr(mem_req_addr)
   );

   nwe_entry_decode #(
      .ENTRY_W(ENTRY_W), .PA_W(PA_W), .OFF_W(OFF_W)
   ) u_dec (
      .data(mem_rsp_data), .present(ent_present), .frame(ent_frame)
   );

   nwe_walk_fsm #(
      .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .G_LVL(G_LVL), .N_LVL(N_LVL),
      .GSEL_W(GSEL_W), .NSEL_W(NSEL_W), .CNT_W(CNT_W)
   ) u_fsm (
      .clk(clk),
      .rst_n(rst_n),
      .req_valid(req_valid),
      .req_gva(req_gva),
      .req_groot_frame(req_groot[PA_W-1:OFF_W]),
      .req_nroot_frame(req_nroot[PA_W-1:OFF_W]),
      .req_ready(req_ready),
      .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready),
      .mem_rsp_valid(mem_rsp_valid),
      .ent_present(ent_present),
      .ent_frame(ent_frame),
      .rsp_valid(rsp_valid),
      .rsp_ready(rsp_ready),
      .rsp_spa(rsp_spa),
      .rsp_fault(rsp_fault),
      .rsp_fault_nested(rsp_fault_nested),
      .read_count(dbg_read_count),
      .gva_q(gva_q),
      .gpa_frame_q(gpa_frame_q),
      .g_lvl(g_lvl),
      .n_lvl(n_lvl),
      .in_guest(in_guest),
      .walk_base(walk_base)
   );
endmodule

// File: rtl/nwe_checker.sv
module nwe_checker #(
   parameter int PA_W  = 52,
   parameter int G_LVL = 4,
   parameter int N_LVL = 4,
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_ready,
   input logic             mem_req_valid,
   input logic             mem_req_ready,
   input logic [PA_W-1:0]  mem_req_addr,
   input logic             rsp_valid,
   input logic             rsp_ready,
   input logic [PA_W-1:0]  rsp_spa,
   input logic             rsp_fault,
   input logic             rsp_fault_nested,
   input logic [CNT_W-1:0] dbg_read_count
);
   localparam int TOTAL_RD = G_LVL*N_LVL + G_LVL + N_LVL;

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!mem_req_valid && !rsp_valid)); // R1

   AST_ENTRY_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (mem_req_addr[2:0] == 3'b000)); // R2

   AST_FULL_WALK_READS: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_fault) |-> (dbg_read_count == CNT_W'(TOTAL_RD))); // R5

   AST_READ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_read_count <= CNT_W'(TOTAL_RD)); // R5

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_ready) |=>
         (dbg_read_count == $past(dbg_read_count) + CNT_W'(1))); // R5

   AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_spa == '0)); // R6

   AST_NESTED_FLAG_ONLY_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_fault) |-> !rsp_fault_nested); // R7

   AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=>
         (rsp_valid && $stable(rsp_spa) && $stable(rsp_fault) && $stable(rsp_fault_nested))); // R8

   AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R9
endmodule

bind nested_walk_engine nwe_checker #(
   .PA_W(PA_W), .G_LVL(G_LVL), .N_LVL(N_LVL), .CNT_W(CNT_W)
) u_nwe_checker (
   .clk(clk),
   .rst_n(rst_n),
   .req_ready(req_ready),
   .mem_req_valid(mem_req_valid),
   .mem_req_ready(mem_req_ready),
   .mem_req_addr(mem_req_addr),
   .rsp_valid(rsp_valid),
   .rsp_ready(rsp_ready),
   .rsp_spa(rsp_spa),
   .rsp_fault(rsp_fault),
   .rsp_fault_nested(rsp_fault_nested),
   .dbg_read_count(dbg_read_count)
);

// File: tb/nested_walk_engine_bench.sv
module nested_walk_engine_bench;
   localparam int CLK_PERIOD = 10;
   localparam logic [39:0] NROOT = 40'h8_0000;
   localparam logic [39:0] GROOT = 40'h0_0050;
   localparam logic [39:0] OFS   = 40'h4_0000;
   localparam logic [39:0] SWZ   = 40'h5_5555;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [47:0] req_gva = '0;
   logic [51:0] req_groot = '0;
   logic [51:0] req_nroot = '0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [51:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_data = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b0;
   logic [51:0] rsp_spa;
   logic        rsp_fault;
   logic        rsp_fault_nested;
   logic [7:0]  dbg_read_count;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [63:0] mem [logic [51:0]];
   logic [51:0] rd_log [64];
   int          rd_n = 0;
   int          lat_ctr = 0;
   logic [39:0] nalloc = 40'h9_0000;
   logic [39:0] galloc = 40'h0_0100;

   always #(CLK_PERIOD/2) clk = ~clk;

   nested_walk_engine u_nested_walk_engine (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_gva(req_gva),
      .req_groot(req_groot), .req_nroot(req_nroot),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_spa(rsp_spa),
      .rsp_fault(rsp_fault), .rsp_fault_nested(rsp_fault_nested),
      .dbg_read_count(dbg_read_count)
   );

   task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", rq, act, exp);
      end
   endtask

   // Junk in bits 63:52 and 11:1 must not matter (R10).
   function automatic logic [63:0] mk_ent(input logic [39:0] fr);
      return {12'hA5C, fr, 11'h7F2, 1'b1};
   endfunction

   function automatic logic [51:0] ea(input logic [39:0] tbl, input logic [8:0] idx);
      return {tbl, 12'h000} + {40'h0, idx, 3'b000};
   endfunction

   task automatic nmap(input logic [39:0] gfr, input logic [39:0] sfr);
      logic [39:0] t;
      logic [51:0] a;
      t = NROOT;
      for (int l = 0; l < 4; l++) begin
         a = ea(t, gfr[9*(3-l) +: 9]);
         if (l == 3) mem[a] = mk_ent(sfr);
         else begin
            if (!mem.exists(a)) begin
               mem[a] = mk_ent(nalloc);
               nalloc = nalloc + 40'd1;
            end
            t = mem[a][51:12];
         end
      end
   endtask

   task automatic gmap(input logic [47:0] gva, input logic [39:0] dfr);
      logic [39:0] t;
      logic [51:0] a;
      t = GROOT;
      for (int l = 0; l < 4; l++) begin
         a = ea(t + OFS, gva[12 + 9*(3-l) +: 9]);
         if (l == 3) mem[a] = mk_ent(dfr);
         else begin
            if (!mem.exists(a)) begin
               mem[a] = mk_ent(galloc);
               nmap(galloc, galloc + OFS);
               galloc = galloc + 40'd1;
            end
            t = mem[a][51:12];
         end
      end
   endtask

   // Memory responder with varying request and response delays (R9).
   initial begin
      logic [51:0] first_addr;
      int lat;
      int rlat;
      forever begin
         @(negedge clk);
         mem_req_ready = 1'b0;
         mem_rsp_valid = 1'b0;
         if (mem_req_valid) begin
            first_addr = mem_req_addr;
            lat  = lat_ctr % 3;
            rlat = (lat_ctr / 3) % 4;
            lat_ctr++;
            repeat (lat) @(negedge clk);
            chk(mem_req_valid && (mem_req_addr == first_addr), "R9 request held",
                64'(mem_req_addr), 64'(first_addr));
            if (rd_n < 64) rd_log[rd_n] = mem_req_addr;
            rd_n++;
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            repeat (rlat) @(negedge clk);
            mem_rsp_data  = mem.exists(mem_req_addr_q()) ? mem[mem_req_addr_q()] : 64'h0;
            mem_rsp_valid = 1'b1;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
         end
      end
   end

   function automatic logic [51:0] mem_req_addr_q();
      return rd_log[(rd_n - 1) % 64];
   endfunction

   task automatic run_walk(input logic [47:0] gva, input logic exp_fault, input logic exp_nested,
                           input logic [51:0] exp_spa, input int exp_reads, input string tag);
      logic [51:0] spa0;
      rd_n = 0;
      @(negedge clk);
      req_gva   = gva;
      req_groot = {GROOT, 12'h123};
      req_nroot = {NROOT, 12'h000};
      req_valid = 1'b1;
      @(negedge clk);
      // keep a competing request pending during the walk (R1)
      req_gva = gva ^ 48'h0F0F_0000_0000;
      while (!rsp_valid) @(negedge clk);
      chk(!req_ready, {"R1 busy ", tag}, 64'(req_ready), 64'h0);
      req_valid = 1'b0;
      chk(rsp_fault == exp_fault, {"R6 fault flag ", tag}, 64'(rsp_fault), 64'(exp_fault));
      chk(rsp_fault_nested == exp_nested, {"R7 nested flag ", tag}, 64'(rsp_fault_nested), 64'(exp_nested));
      chk(rsp_spa == exp_spa, {"R4 spa ", tag}, 64'(rsp_spa), 64'(exp_spa));
      chk(dbg_read_count == 8'(exp_reads), {"R5 read count ", tag}, 64'(dbg_read_count), 64'(exp_reads));
      chk(rd_n == exp_reads, {"R6 reads at port ", tag}, 64'(rd_n), 64'(exp_reads));
      chk(rd_log[0] == ea(NROOT, GROOT[35:27]), {"R3 first read ", tag},
          64'(rd_log[0]), 64'(ea(NROOT, GROOT[35:27])));
      if (exp_reads >= 5)
         chk(rd_log[4] == ea(GROOT + OFS, gva[47:39]), {"R2 guest top read ", tag},
             64'(rd_log[4]), 64'(ea(GROOT + OFS, gva[47:39])));
      spa0 = rsp_spa;
      repeat (2) @(negedge clk);
      chk(rsp_valid && rsp_spa == spa0, {"R8 hold ", tag}, 64'(rsp_spa), 64'(spa0));
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      chk(req_ready && !rsp_valid && rd_n == exp_reads, {"R1 idle after ", tag},
          64'(rd_n), 64'(exp_reads));
   endtask

   function automatic logic [47:0] sweep_gva(input int k);
      return {9'(k + 1), 9'(3*k + 2), 9'(5*k + 7), 9'(7*k + 1), 12'(k * 12'h155)};
   endfunction

   initial begin
      logic [47:0] g;
      logic [39:0] dfr;
      nmap(GROOT, GROOT + OFS);
      for (int k = 0; k < 8; k++) begin
         dfr = 40'h300 + 40'(k);
         gmap(sweep_gva(k), dfr);
         nmap(dfr, dfr ^ SWZ);
      end
      gmap({9'd200, 9'd9, 9'd9, 9'd9, 12'h0}, 40'h08_0000_0000);

      repeat (3) @(negedge clk);
      chk(req_ready == 1'b0 || rst_n == 1'b0, "R1 in reset", 64'(req_ready), 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1 reset idle", 64'(req_ready), 64'h1);
      chk(!rsp_valid && !mem_req_valid, "R9 reset quiet", 64'({rsp_valid, mem_req_valid}), 64'h0);
      chk(dbg_read_count == 8'h0, "R5 reset count", 64'(dbg_read_count), 64'h0);

      for (int pass = 0; pass < 2; pass++) begin
         for (int k = 0; k < 8; k++) begin
            g   = sweep_gva(k);
            dfr = (40'h300 + 40'(k)) ^ SWZ;
            run_walk(g, 1'b0, 1'b0, {dfr, g[11:0]}, 24, "R10 walk");
         end
      end

      // guest fault at the third guest level: 4+1+4+1+4+1 reads (R6)
      run_walk({9'd1, 9'd2, 9'd100, 9'd3, 12'h0}, 1'b1, 1'b0, 52'h0, 15, "R6 guest");
      // nested fault on the final nested walk: 20 + 1 reads (R7)
      run_walk({9'd200, 9'd9, 9'd9, 9'd9, 12'hABC}, 1'b1, 1'b1, 52'h0, 21, "R7 nested");
      // translation still correct after faults
      g = sweep_gva(3);
      run_walk(g, 1'b0, 1'b0, {(40'h303) ^ SWZ, g[11:0]}, 24, "R4 after fault");

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R3 watchdog act=%0d exp=%0d", 200000, 0);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule